// File: doc/BRIEF.md
# Infrared Pulse Line Codec

This block sits between a UART shift engine and an infrared transceiver. On the transmit side it watches the UART's serial output. It turns every logic-0 bit into one short high pulse on the IR transmit pin and leaves logic-1 bits dark. Pulse width can follow either of two timing sources. In normal mode it is three ticks of the 16x oversampling strobe. In low-power mode it is three periods of a slow clock, divided from the system clock by an 8-bit prescaler.

On the receive side, the active-low IR input passes through a two-flop synchronizer. A width filter then measures each low pulse in system clocks against the prescaler value. When a pulse is accepted, the decoded serial output goes low for one bit period, which is sixteen oversampling ticks. The link is half-duplex. From the tick that carries a start bit until the frame's last bit period has run out, the receive input is ignored and the decoded output stays high.

Top module: `ir_pulse_codec`

## Requirements
- R1: While reset is asserted and just after its release, `irTx` is 0 and `rxData` is 1.
- R2: A frame begins on a tick where `txData` is 0 while idle. Bit k of the frame starts 16k ticks later. Each 0 bit, the start bit included, gives exactly one rising edge of `irTx`, one clock after the tick that opens that bit. A 1 bit gives no pulse.
- R3: In normal mode (`lowPower`=0), each transmit pulse stays high for exactly 3 tick periods.
- R4: In low-power mode with `prescale`=P≥1, each transmit pulse stays high for exactly 3·P system clocks.
- R5: In low-power mode with `prescale`=0, `irTx` stays 0.
- R6: A low pulse on `irRxN` shorter than `prescale` clocks leaves `rxData` at 1.
- R7: A low pulse on `irRxN` of at least 2·`prescale` clocks drives `rxData` low within a few clocks. `rxData` then returns high on the 16th tick after acceptance, so with a tick every T clocks it is low for between 15T+1 and 16T clocks.
- R8: The receive filter and the output timing are the same when `lowPower`=1.
- R9: While a transmit frame is in progress, `rxData` is 1 and pulses on `irRxN` have no effect.
- R10: With `enable`=0, `irTx` is 0, `rxData` is 1, and neither `txData` nor `irRxN` has any effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Codec enable; 0 forces both directions idle |
| lowPower | input | 1 | 1 selects prescaler-timed transmit pulses |
| prescale | input | 8 | Slow-clock divider and receive filter width, in clocks |
| tick16 | input | 1 | One-clock strobe, 16 per bit period |
| txData | input | 1 | NRZ serial output of the UART |
| irRxN | input | 1 | IR receive pin, idle high, pulses low |
| irTx | output | 1 | IR transmit pin, idle low, pulses high |
| rxData | output | 1 | Decoded NRZ data for the UART receiver |

## Verification
The bench builds the block with its default parameters: 16 ticks per bit, 10-bit frames and an 8-bit prescaler. It fires a tick every 4 clocks, so a bit lasts 64 clocks. This short bit lets a sweep of 52 frame bytes compare every pulse position and width against arithmetic from the bit index. It also keeps low-power pulses for prescaler values 0 to 8 inside one bit. The receive filter is swept over prescaler values 1 to 6 in both modes, using pulse widths just under the threshold and well above it.

// File: rtl/ir_pulse_pkg.sv
package ir_pulse_pkg;

  // Strobes the frame sequencer hands to the pulse datapath.
  typedef struct packed {
    logic pulseStart;  // open a transmit pulse on this clock
    logic txBusy;      // a transmit frame is in progress
  } irStrobe_t;

endpackage

// File: rtl/ir_pulse_ctrl.sv
module ir_pulse_ctrl
  import ir_pulse_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int FRAME_BITS = 10
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      tick16,
  input  logic      txData,
  output irStrobe_t strobe
);

  localparam int PHASE_W = $clog2(OVERSAMPLE);
  localparam int BIT_W   = $clog2(FRAME_BITS);

  logic               busy;
  logic [PHASE_W-1:0] phase;   // index of the next tick inside the bit
  logic [BIT_W-1:0]   bitIdx;  // bit of the frame currently on the line

  logic bitEdge;
  logic frameLast;
  logic startIdle;

  assign bitEdge   = tick16 && busy && (phase == '0);
  assign frameLast = (bitIdx == BIT_W'(FRAME_BITS - 1));
  assign startIdle = tick16 && !busy && !txData;

  always_comb begin
    strobe.pulseStart = enable && (startIdle || (bitEdge && !txData));
    strobe.txBusy     = busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      phase  <= '0;
      bitIdx <= '0;
    end else if (!enable) begin
      busy   <= 1'b0;
      phase  <= '0;
      bitIdx <= '0;
    end else if (tick16) begin
      if (!busy) begin
        if (!txData) begin
          busy   <= 1'b1;
          phase  <= PHASE_W'(1);
          bitIdx <= '0;
        end
      end else begin
        phase <= phase + PHASE_W'(1);
        if (phase == '0) begin
          if (frameLast) begin
            if (txData) busy <= 1'b0;
            bitIdx <= '0;
          end else begin
            bitIdx <= bitIdx + BIT_W'(1);
          end
        end
      end
    end
  end

  // R2: a frame can only open on a tick that carries a 0 bit
  p_frame_opens_on_zero_r2 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(tick16 && !txData));

  // R10: a disabled codec holds no frame
  p_no_frame_when_off_r10 : assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !busy);

endmodule

// File: rtl/ir_pulse_dp.sv
module ir_pulse_dp
  import ir_pulse_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int PRESC_W    = 8,
  parameter int PULSE_LEN  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               lowPower,
  input  logic [PRESC_W-1:0] prescale,
  input  logic               tick16,
  input  logic               irRxN,
  input  irStrobe_t          strobe,
  output logic               irTx,
  output logic               rxData
);

  localparam int LEN_W  = $clog2(PULSE_LEN + 1);
  localparam int HOLD_W = $clog2(OVERSAMPLE + 1);

  // ---------------- transmit pulse shaper ----------------
  logic [LEN_W-1:0]   periodsLeft;
  logic [PRESC_W-1:0] lpDiv;       // restartable slow-clock divider
  logic               lpStrobe;
  logic               lpAllowed;
  logic               stepNow;

  assign lpAllowed = (prescale != '0);
  assign lpStrobe  = (lpDiv == prescale - PRESC_W'(1));
  assign stepNow   = lowPower ? lpStrobe : tick16;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irTx        <= 1'b0;
      periodsLeft <= '0;
      lpDiv       <= '0;
    end else if (!enable) begin
      irTx        <= 1'b0;
      periodsLeft <= '0;
      lpDiv       <= '0;
    end else if (strobe.pulseStart && (!lowPower || lpAllowed)) begin
      irTx        <= 1'b1;
      periodsLeft <= LEN_W'(PULSE_LEN - 1);
      lpDiv       <= '0;
    end else if (irTx) begin
      lpDiv <= lpStrobe ? '0 : lpDiv + PRESC_W'(1);
      if (stepNow) begin
        if (periodsLeft == '0) irTx <= 1'b0;
        else                   periodsLeft <= periodsLeft - LEN_W'(1);
      end
    end
  end

  // ---------------- receive synchronizer and filter ----------------
  logic               rxMeta;
  logic               rxSync;
  logic [PRESC_W-1:0] lowRun;
  logic [PRESC_W-1:0] acceptAt;
  logic               accept;
  logic [HOLD_W-1:0]  holdLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      rxMeta <= irRxN;
      rxSync <= rxMeta;
    end
  end

  assign acceptAt = (prescale == '0) ? '0 : prescale - PRESC_W'(1);
  assign accept   = !rxSync && (lowRun == acceptAt) && !strobe.txBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun <= '0;
    end else if (!enable || strobe.txBusy || rxSync) begin
      lowRun <= '0;
    end else if (lowRun != '1) begin
      lowRun <= lowRun + PRESC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData   <= 1'b1;
      holdLeft <= '0;
    end else if (!enable || strobe.txBusy) begin
      rxData   <= 1'b1;
      holdLeft <= '0;
    end else if (accept) begin
      rxData   <= 1'b0;
      holdLeft <= HOLD_W'(OVERSAMPLE);
    end else if (tick16 && (holdLeft != '0)) begin
      holdLeft <= holdLeft - HOLD_W'(1);
      if (holdLeft == HOLD_W'(1)) rxData <= 1'b1;
    end
  end

  // R2: every transmit pulse is opened by the sequencer
  p_rise_from_start_r2 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(irTx) |-> $past(strobe.pulseStart));

  // R3: in normal mode a pulse can only end on a tick
  p_normal_ends_on_tick_r3 : assert property (@(posedge clk) disable iff (!rstN)
    enable && !lowPower && irTx && !tick16 |=> irTx);

  // R5: a zero prescaler keeps the low-power transmitter dark
  p_lp_zero_dark_r5 : assert property (@(posedge clk) disable iff (!rstN)
    enable && lowPower && (prescale == '0) && !irTx |=> !irTx);

  // R7: the decoded line only falls after a low receive sample
  p_fall_needs_low_r7 : assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxData) |-> !$past(rxSync));

  // R9: receive path locked out during a transmit frame
  p_lockout_r9 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.txBusy |=> rxData);

  // R10: disabled codec idles both pins
  p_idle_when_off_r10 : assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !irTx && rxData);

endmodule

// File: rtl/ir_pulse_codec.sv
module ir_pulse_codec
  import ir_pulse_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int FRAME_BITS = 10,
  parameter int PRESC_W    = 8,
  parameter int PULSE_LEN  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               lowPower,
  input  logic [PRESC_W-1:0] prescale,
  input  logic               tick16,
  input  logic               txData,
  input  logic               irRxN,
  output logic               irTx,
  output logic               rxData
);

  irStrobe_t strobe;

  ir_pulse_ctrl #(
    .OVERSAMPLE (OVERSAMPLE),
    .FRAME_BITS (FRAME_BITS)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .tick16 (tick16),
    .txData (txData),
    .strobe (strobe)
  );

  ir_pulse_dp #(
    .OVERSAMPLE (OVERSAMPLE),
    .PRESC_W    (PRESC_W),
    .PULSE_LEN  (PULSE_LEN)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .lowPower (lowPower),
    .prescale (prescale),
    .tick16   (tick16),
    .irRxN    (irRxN),
    .strobe   (strobe),
    .irTx     (irTx),
    .rxData   (rxData)
  );

endmodule

// File: tb/ir_pulse_codec_bench.sv
`timescale 1ns/1ps
module ir_pulse_codec_bench;

  localparam int T   = 4;   // clocks per tick
  localparam int OVS = 16;  // ticks per bit

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b1;
  logic       lowPower = 1'b0;
  logic [7:0] prescale = 8'd3;
  logic       tick16;
  logic       txData = 1'b1;
  logic       irRxN = 1'b1;
  logic       irTx;
  logic       rxData;

  int checks = 0;
  int errors = 0;
  int tickCnt = 0;

  always #10 clk = ~clk;

  always @(negedge clk) tickCnt <= (tickCnt == T - 1) ? 0 : tickCnt + 1;
  assign tick16 = (tickCnt == 0);

  ir_pulse_codec u_ir_pulse_codec (
    .clk(clk), .rstN(rstN), .enable(enable), .lowPower(lowPower),
    .prescale(prescale), .tick16(tick16), .txData(txData), .irRxN(irRxN),
    .irTx(irTx), .rxData(rxData)
  );

  // Output monitor, sampled on the falling edge
  int   cyc = 0;
  int   nPulse = 0;
  int   curW = 0;
  int   rxLowTot = 0;
  logic prevTx = 1'b0;
  int   riseAt[256];
  int   widthOf[256];

  always @(negedge clk) begin
    if (irTx && !prevTx) riseAt[nPulse % 256] = cyc;
    if (irTx) curW++;
    if (!irTx && prevTx) begin
      widthOf[nPulse % 256] = curW;
      curW = 0;
      nPulse++;
    end
    if (!rxData) rxLowTot++;
    prevTx = irTx;
    cyc++;
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic waitTick();
    do begin
      @(negedge clk);
      #1;
    end while (!tick16);
  endtask

  task automatic sendFrame(input logic [9:0] bits);
    for (int i = 0; i < 10; i++) begin
      waitTick();
      txData = bits[i];
      repeat (OVS - 1) waitTick();
    end
    txData = 1'b1;
    repeat (40) waitTick();
  endtask

  task automatic txFrame(input logic [7:0] b, input int expW, input bit expNone,
                         input string tag);
    logic [9:0] bits;
    int zeroIdx[10];
    int nz;
    int base;
    int got;
    nz = 0;
    bits = {1'b1, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      if (!bits[i]) begin
        zeroIdx[nz] = i;
        nz++;
      end
    end
    if (expNone) nz = 0;
    base = nPulse;
    sendFrame(bits);
    got = nPulse - base;
    check(got == nz, {tag, " R2 pulse count"}, got, nz);
    for (int k = 0; k < nz && k < got; k++) begin
      check(widthOf[(base + k) % 256] == expW, {tag, " pulse width"},
            widthOf[(base + k) % 256], expW);
      check(riseAt[(base + k) % 256] - riseAt[base % 256] == zeroIdx[k] * OVS * T,
            "R2 pulse position",
            riseAt[(base + k) % 256] - riseAt[base % 256], zeroIdx[k] * OVS * T);
    end
  endtask

  task automatic rxTest(input int w, input bit expAcc, input string tag);
    int base;
    int got;
    base = rxLowTot;
    @(negedge clk); #1;
    irRxN = 1'b0;
    repeat (w) @(negedge clk);
    #1;
    irRxN = 1'b1;
    repeat (100) @(negedge clk);
    #1;
    got = rxLowTot - base;
    if (expAcc)
      check(got >= 15 * T + 1 && got <= 16 * T, {tag, " accepted low time"}, got, 16 * T);
    else
      check(got == 0, {tag, " rejected glitch"}, got, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(irTx == 1'b0, "R1 irTx in reset", int'(irTx), 0);
    check(rxData == 1'b1, "R1 rxData in reset", int'(rxData), 1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(irTx == 1'b0, "R1 irTx after reset", int'(irTx), 0);
    check(rxData == 1'b1, "R1 rxData after reset", int'(rxData), 1);

    // R2 / R3: byte sweep in normal mode
    for (int i = 0; i < 52; i++) txFrame(8'(i * 5), 3 * T, 1'b0, "R3");

    // R4 / R5: prescaler sweep in low-power mode
    lowPower = 1'b1;
    for (int p = 0; p <= 8; p++) begin
      prescale = 8'(p);
      txFrame(8'h00, 3 * p, p == 0, (p == 0) ? "R5" : "R4");
      txFrame(8'hA5, 3 * p, p == 0, (p == 0) ? "R5" : "R4");
    end

    // R6 / R7 / R8: receive filter in both modes
    for (int m = 0; m < 2; m++) begin
      lowPower = m[0];
      for (int p = 1; p <= 6; p++) begin
        prescale = 8'(p);
        if (p > 1) rxTest(p - 1, 1'b0, (m == 1) ? "R8" : "R6");
        rxTest(2 * p, 1'b1, (m == 1) ? "R8" : "R7");
        rxTest(3 * p + 5, 1'b1, (m == 1) ? "R8" : "R7");
      end
    end

    // R9: receive pulse in the middle of a transmit frame
    begin
      int baseRx;
      lowPower = 1'b0;
      prescale = 8'd2;
      baseRx = rxLowTot;
      fork
        sendFrame(10'b1_0000_0000_0);
        begin
          repeat (150) @(negedge clk);
          #1 irRxN = 1'b0;
          repeat (40) @(negedge clk);
          #1 irRxN = 1'b1;
        end
      join
      check(rxLowTot - baseRx == 0, "R9 rx ignored during frame", rxLowTot - baseRx, 0);
    end

    // R10: disabled codec
    begin
      int baseRx;
      int baseTx;
      enable = 1'b0;
      baseRx = rxLowTot;
      baseTx = nPulse;
      fork
        sendFrame(10'b1_0000_0000_0);
        begin
          repeat (100) @(negedge clk);
          #1 irRxN = 1'b0;
          repeat (40) @(negedge clk);
          #1 irRxN = 1'b1;
        end
      join
      check(nPulse - baseTx == 0, "R10 no tx pulse when off", nPulse - baseTx, 0);
      check(rxLowTot - baseRx == 0, "R10 no rx output when off", rxLowTot - baseRx, 0);
      enable = 1'b1;
      txFrame(8'hF0, 3 * T, 1'b0, "R10 re-enable R3");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule